// File: doc/BRIEF.md
# Indicator Pin Control and Channel-Busy Source Select

This block drives the general-purpose indicator pads of a wireless MAC and reports their levels. It also chooses where the channel-busy (clear-channel-assessment) status comes from. Each indicator pad has three configuration bits: an enable, a data value and a drive type. With these bits the pad becomes an input, a push-pull output or an open-drain output. Bit 0 of the indicator vectors is the activity pad and bit 1 is the link pad. A shared user pad is configured the same way. That pad can also be switched over to carry an external channel-busy signal, which then replaces the internal CCA result.

The busy status exposes three things to the embedded controller. The first is a busy level. The second is a sticky change flag, set on either edge of the selected busy signal. The third is a sticky busy-to-clear flag, set on a falling edge. Each flag has its own write-one-to-clear strobe and its own mask, and raises an interrupt request while it is set and unmasked. The status outputs keep the same meaning whichever source is selected, so firmware only changes the select bit. When the select bit changes, the new source is sampled once before edge detection resumes, so the switch itself is never reported as an event.

Top module: `wmac_pin_ctrl`

## Requirements
- R1: After synchronous reset, every pad output-enable is 0 (all pads are inputs). The busy level, both flags and both interrupt requests are 0.
- R2: A pad whose enable bit is 0 has output-enable 0 one clock later, whatever its data and drive-type bits.
- R3: An enabled pad with drive-type 1 (push-pull) has output-enable 1 and pad output equal to its data bit, one clock later.
- R4: An enabled pad with drive-type 0 (open-drain) never drives high. With data 0 it has output-enable 1 and output 0. With data 1 it has output-enable 0, so the pad floats.
- R5: Each level status bit equals its pad input as sampled two clocks earlier, whatever the pad's configuration.
- R6: While the external-busy select is 1, the user pad has output-enable 0 one clock later, whatever its enable, data and drive-type bits.
- R7: With select 0, the busy level follows the internal CCA input one clock later. With select 1, it follows the user pad input three clocks later, and the internal input has no effect on the busy level or the flags.
- R8: The change flag sets on every rising or falling edge of the selected busy signal. It stays set until a write-one-to-clear strobe is applied.
- R9: The busy-to-clear flag sets only on a falling edge of the selected busy signal. A rising edge leaves it unchanged.
- R10: When a flag's set event and its clear strobe fall in the same cycle, the flag stays set.
- R11: Each interrupt request is 1 exactly while its flag is 1 and its mask bit is 0.
- R12: A change of the source select sets neither flag. The busy level takes the newly selected source's value on the clock after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ind_en_i | input | IND_PINS | Indicator pad enable (0 = input) |
| ind_dat_i | input | IND_PINS | Indicator pad data value |
| ind_pp_i | input | IND_PINS | Indicator drive type (1 = push-pull, 0 = open-drain) |
| ind_pad_in_i | input | IND_PINS | Indicator pad input level |
| ind_pad_out_o | output | IND_PINS | Indicator pad output value |
| ind_pad_oe_o | output | IND_PINS | Indicator pad output-enable |
| ind_level_o | output | IND_PINS | Synchronised indicator pad level status |
| usr_en_i | input | 1 | User pad enable |
| usr_dat_i | input | 1 | User pad data value |
| usr_pp_i | input | 1 | User pad drive type |
| usr_pad_in_i | input | 1 | User pad input level, also the external busy signal |
| usr_pad_out_o | output | 1 | User pad output value |
| usr_pad_oe_o | output | 1 | User pad output-enable |
| usr_level_o | output | 1 | Synchronised user pad level status |
| ext_cca_sel_i | input | 1 | 1 selects the user pad as the busy source |
| int_cca_i | input | 1 | Internal CCA busy result (synchronous to clk) |
| chg_w1c_i | input | 1 | Clear strobe for the change flag |
| clr_w1c_i | input | 1 | Clear strobe for the busy-to-clear flag |
| chg_mask_i | input | 1 | Mask for the change interrupt |
| clr_mask_i | input | 1 | Mask for the busy-to-clear interrupt |
| busy_o | output | 1 | Channel-busy level |
| chg_flag_o | output | 1 | Sticky busy-change flag |
| clr_flag_o | output | 1 | Sticky busy-to-clear flag |
| irq_chg_o | output | 1 | Change interrupt request |
| irq_clr_o | output | 1 | Busy-to-clear interrupt request |

## Verification
The bench builds the block with its defaults: two indicator pads and a two-stage synchronizer. At that size the configuration space is small enough to cover completely. Every combination of enable, data and drive type is applied to each indicator pad, and the user pad gets every combination under both source selects. All eight level patterns across the three pads are checked at the exact synchronizer latency. The busy path is then driven through both edges from each source, through masked and unmasked interrupts, through a clear that collides with a set event, and through a source switch in which the two sources disagree.

// File: rtl/wmac_pin_pkg.sv
// Shared types and helpers for the indicator pin controller.
// Assumes one clock domain for all control bits; pad inputs are asynchronous.
package wmac_pin_pkg;

    // Drive state presented to one tri-state pad.
    typedef struct packed {
        logic out;
        logic oe;
    } pad_drv_t;

    // Maps enable/data/drive-type to the pad drive state.
    // Open-drain pulls low only; a high data value releases the pad.
    function automatic pad_drv_t calc_drive(input logic en, input logic dat, input logic pp);
        pad_drv_t d;
        d.out = 1'b0;
        d.oe  = 1'b0;
        if (en) begin
            if (pp) begin
                d.out = dat;
                d.oe  = 1'b1;
            end else begin
                d.out = 1'b0;
                d.oe  = ~dat;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wmac_sync.sv
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes STAGES >= 2; all bits are synchronised independently.
module wmac_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the asynchronous sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wmac_pin_drive.sv
// Registered drive logic for one configurable pad.
// force_in_i overrides all configuration bits and releases the pad.
// Assumes control bits are synchronous to clk.
module wmac_pin_drive
    import wmac_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dat_i,
    input  logic pp_i,
    input  logic force_in_i,
    output logic pad_out_o,
    output logic pad_oe_o
);
    pad_drv_t drv_q;

    // Register the pad drive so the pad sees glitch-free control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (force_in_i) begin
            drv_q <= '0;
        end else begin
            drv_q <= calc_drive(en_i, dat_i, pp_i);
        end
    end

    assign pad_out_o = drv_q.out;
    assign pad_oe_o  = drv_q.oe;

    // R2: a disabled or forced pad is released on the next clock.
    a_r2_disabled_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || force_in_i) |=> !pad_oe_o);

    // R4: open-drain mode never presents a high level.
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !pp_i && !force_in_i) |=> !pad_out_o);
endmodule

// File: rtl/wmac_cca_event.sv
// Channel-busy source mux, edge detection and sticky flags with masks.
// Assumes int_busy_i is synchronous and ext_busy_i is already synchronised.
// On a source switch the new source is resampled with no event reported.
module wmac_cca_event (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic int_busy_i,
    input  logic ext_busy_i,
    input  logic chg_w1c_i,
    input  logic clr_w1c_i,
    input  logic chg_mask_i,
    input  logic clr_mask_i,
    output logic busy_o,
    output logic chg_flag_o,
    output logic clr_flag_o,
    output logic irq_chg_o,
    output logic irq_clr_o
);
    logic sel_q;
    logic prev_q;
    logic chg_q;
    logic clr_q;
    logic busy_sel;
    logic switching;
    logic chg_evt;
    logic fall_evt;

    // Pick the active busy source and detect edges against the last sample.
    always_comb begin
        busy_sel  = sel_i ? ext_busy_i : int_busy_i;
        switching = (sel_i != sel_q);
        chg_evt   = !switching && (busy_sel != prev_q);
        fall_evt  = !switching && prev_q && !busy_sel;
    end

    // Track the select and the last busy sample used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sel_q  <= sel_i;
            prev_q <= busy_sel;
        end
    end

    // Sticky flags: a set event wins over a same-cycle clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            chg_q <= chg_evt  | (chg_q & ~chg_w1c_i);
            clr_q <= fall_evt | (clr_q & ~clr_w1c_i);
        end
    end

    assign busy_o     = prev_q;
    assign chg_flag_o = chg_q;
    assign clr_flag_o = clr_q;
    assign irq_chg_o  = chg_q & ~chg_mask_i;
    assign irq_clr_o  = clr_q & ~clr_mask_i;

    // R12: a select change never raises either flag.
    a_r12_switch_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        switching |=> (!$rose(chg_flag_o) && !$rose(clr_flag_o)));

    // R9: the busy-to-clear flag only rises when busy fell.
    a_r9_clr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_flag_o) |-> ($past(busy_o) && !busy_o));

    // R8: the change flag holds without a clear strobe.
    a_r8_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag_o && !chg_w1c_i) |=> chg_flag_o);

    // R8: a new change flag always accompanies a moved busy level.
    a_r8_chg_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_flag_o) |-> (busy_o != $past(busy_o)));
endmodule

// File: rtl/wmac_pin_ctrl.sv
// Indicator pad controller with channel-busy source select (top level).
// Drives IND_PINS indicator pads and one shared user pad, synchronises
// all pad levels for status, and routes the internal or external busy
// source into the edge/flag logic. Selecting the external source forces
// the user pad to an input.
module wmac_pin_ctrl #(
    parameter int IND_PINS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IND_PINS-1:0] ind_en_i,
    input  logic [IND_PINS-1:0] ind_dat_i,
    input  logic [IND_PINS-1:0] ind_pp_i,
    input  logic [IND_PINS-1:0] ind_pad_in_i,
    output logic [IND_PINS-1:0] ind_pad_out_o,
    output logic [IND_PINS-1:0] ind_pad_oe_o,
    output logic [IND_PINS-1:0] ind_level_o,
    input  logic                usr_en_i,
    input  logic                usr_dat_i,
    input  logic                usr_pp_i,
    input  logic                usr_pad_in_i,
    output logic                usr_pad_out_o,
    output logic                usr_pad_oe_o,
    output logic                usr_level_o,
    input  logic                ext_cca_sel_i,
    input  logic                int_cca_i,
    input  logic                chg_w1c_i,
    input  logic                clr_w1c_i,
    input  logic                chg_mask_i,
    input  logic                clr_mask_i,
    output logic                busy_o,
    output logic                chg_flag_o,
    output logic                clr_flag_o,
    output logic                irq_chg_o,
    output logic                irq_clr_o
);
    localparam int SYNC_W = IND_PINS + 1;
    localparam int USR_IX = IND_PINS;

    logic [SYNC_W-1:0] pad_sync;

    // One synchronizer bank for all pad levels; the user bit also feeds CCA.
    wmac_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({usr_pad_in_i, ind_pad_in_i}),
        .q_o   (pad_sync)
    );

    assign ind_level_o = pad_sync[IND_PINS-1:0];
    assign usr_level_o = pad_sync[USR_IX];

    // One drive block per indicator pad.
    for (genvar g = 0; g < IND_PINS; g++) begin : g_ind
        wmac_pin_drive u_drv (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (ind_en_i[g]),
            .dat_i      (ind_dat_i[g]),
            .pp_i       (ind_pp_i[g]),
            .force_in_i (1'b0),
            .pad_out_o  (ind_pad_out_o[g]),
            .pad_oe_o   (ind_pad_oe_o[g])
        );
    end

    // User pad: the external-busy select forces it to an input.
    wmac_pin_drive u_usr_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (usr_en_i),
        .dat_i      (usr_dat_i),
        .pp_i       (usr_pp_i),
        .force_in_i (ext_cca_sel_i),
        .pad_out_o  (usr_pad_out_o),
        .pad_oe_o   (usr_pad_oe_o)
    );

    wmac_cca_event u_cca (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (ext_cca_sel_i),
        .int_busy_i (int_cca_i),
        .ext_busy_i (pad_sync[USR_IX]),
        .chg_w1c_i  (chg_w1c_i),
        .clr_w1c_i  (clr_w1c_i),
        .chg_mask_i (chg_mask_i),
        .clr_mask_i (clr_mask_i),
        .busy_o     (busy_o),
        .chg_flag_o (chg_flag_o),
        .clr_flag_o (clr_flag_o),
        .irq_chg_o  (irq_chg_o),
        .irq_clr_o  (irq_clr_o)
    );

    // R6: external busy select releases the user pad on the next clock.
    a_r6_ext_forces_input: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cca_sel_i |=> !usr_pad_oe_o);
endmodule

// File: tb/wmac_pin_ctrl_tb.sv
// Self-checking bench for wmac_pin_ctrl: exhaustive pad configuration
// sweeps, level latency and busy-path scenarios.
module wmac_pin_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] ind_en = '0, ind_dat = '0, ind_pp = '0, ind_pad_in = '0;
    logic [NP-1:0] ind_pad_out, ind_pad_oe, ind_level;
    logic usr_en = 0, usr_dat = 0, usr_pp = 0, usr_pad_in = 0;
    logic usr_pad_out, usr_pad_oe, usr_level;
    logic sel = 0, int_cca = 0, chg_w1c = 0, clr_w1c = 0, chg_mask = 0, clr_mask = 0;
    logic busy, chg_flag, clr_flag, irq_chg, irq_clr;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wmac_pin_ctrl #(.IND_PINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ind_en_i(ind_en), .ind_dat_i(ind_dat), .ind_pp_i(ind_pp), .ind_pad_in_i(ind_pad_in),
        .ind_pad_out_o(ind_pad_out), .ind_pad_oe_o(ind_pad_oe), .ind_level_o(ind_level),
        .usr_en_i(usr_en), .usr_dat_i(usr_dat), .usr_pp_i(usr_pp), .usr_pad_in_i(usr_pad_in),
        .usr_pad_out_o(usr_pad_out), .usr_pad_oe_o(usr_pad_oe), .usr_level_o(usr_level),
        .ext_cca_sel_i(sel), .int_cca_i(int_cca), .chg_w1c_i(chg_w1c), .clr_w1c_i(clr_w1c),
        .chg_mask_i(chg_mask), .clr_mask_i(clr_mask),
        .busy_o(busy), .chg_flag_o(chg_flag), .clr_flag_o(clr_flag),
        .irq_chg_o(irq_chg), .irq_clr_o(irq_clr)
    );

    // Advance one clock and settle past the edge before sampling.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Clear both flags with a one-cycle strobe.
    task automatic clear_flags();
        chg_w1c = 1; clr_w1c = 1;
        tick();
        chg_w1c = 0; clr_w1c = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 ind oe", ind_pad_oe, 0);
        chk("R1 usr oe", usr_pad_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 flags", {chg_flag, clr_flag}, 0);
        chk("R1 irqs", {irq_chg, irq_clr}, 0);
        rst_n = 1;
        tick();

        // R2 R3 R4: exhaustive sweep per indicator pad
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic en, dat, pp, eoe, eout;
                en = c[0]; dat = c[1]; pp = c[2];
                ind_en = '0; ind_dat = '0; ind_pp = '0;
                ind_en[p] = en; ind_dat[p] = dat; ind_pp[p] = pp;
                tick();
                eoe  = en & (pp | ~dat);
                eout = en & pp & dat;
                if (!en) chk("R2 ind disabled oe", ind_pad_oe[p], 0);
                else if (pp) begin
                    chk("R3 ind push-pull oe", ind_pad_oe[p], 1);
                    chk("R3 ind push-pull out", ind_pad_out[p], dat);
                end else begin
                    chk("R4 ind open-drain oe", ind_pad_oe[p], eoe);
                    chk("R4 ind open-drain out", ind_pad_out[p], eout);
                end
                chk("R2 other pad released", ind_pad_oe[1-p], 0);
            end
        end
        ind_en = '0;

        // R6 plus R2-R4 on the user pad under both selects
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic eoe, eout;
                sel = s[0];
                usr_en = c[0]; usr_dat = c[1]; usr_pp = c[2];
                tick();
                eoe  = !sel & usr_en & (usr_pp | ~usr_dat);
                eout = !sel & usr_en & usr_pp & usr_dat;
                if (sel) chk("R6 usr forced input oe", usr_pad_oe, 0);
                else begin
                    chk("R3_R4 usr oe", usr_pad_oe, eoe);
                    if (eoe) chk("R3_R4 usr out", usr_pad_out, eout);
                end
            end
        end
        sel = 0; usr_en = 0;
        tick(); tick();
        clear_flags();

        // R5: level latency for all pad input patterns, with pads configured
        for (int v = 0; v < 8; v++) begin
            logic [2:0] prev;
            prev = {usr_level, ind_level};
            ind_en = 2'b11; ind_pp = v[1:0]; ind_dat = ~v[1:0];
            {usr_pad_in, ind_pad_in} = v[2:0];
            tick();
            chk("R5 level after one clock", {usr_level, ind_level}, prev);
            tick();
            chk("R5 level after two clocks", {usr_level, ind_level}, v);
        end
        ind_en = '0; usr_pad_in = 0; ind_pad_in = '0;
        tick(); tick();
        clear_flags();

        // R7 R8 R11: internal source rising edge
        int_cca = 1;
        tick();
        chk("R7 internal busy level", busy, 1);
        chk("R8 change on rise", chg_flag, 1);
        chk("R9 no clear flag on rise", clr_flag, 0);
        chk("R11 irq change unmasked", irq_chg, 1);
        tick();
        chk("R8 change sticky", chg_flag, 1);
        chk_mask: begin
            chg_mask = 1;
            #1;
            chk("R11 irq change masked", irq_chg, 0);
            chg_mask = 0;
        end
        clear_flags();
        chk("R8 change cleared by strobe", chg_flag, 0);

        // R9: falling edge
        int_cca = 0;
        tick();
        chk("R9 clear flag on fall", clr_flag, 1);
        chk("R8 change on fall", chg_flag, 1);
        chk("R11 irq clear unmasked", irq_clr, 1);
        clr_mask = 1;
        #1;
        chk("R11 irq clear masked", irq_clr, 0);
        clr_mask = 0;
        clear_flags();
        chk("R9 clear flag cleared", clr_flag, 0);

        // R10: set event collides with clear strobe
        int_cca = 1; chg_w1c = 1;
        tick();
        chg_w1c = 0;
        chk("R10 set wins over clear", chg_flag, 1);
        chg_w1c = 1;
        tick();
        chg_w1c = 0;
        chk("R8 clear with no event", chg_flag, 0);

        // R12: switch from internal busy=1 to external pad=0
        sel = 1;
        tick();
        chk("R12 busy takes new source", busy, 0);
        chk("R12 no change flag on switch", chg_flag, 0);
        chk("R12 no clear flag on switch", clr_flag, 0);
        tick();
        chk("R12 no late event", chg_flag, 0);

        // R7: internal input ignored while external selected
        int_cca = 0;
        tick();
        int_cca = 1;
        tick();
        chk("R7 internal hidden busy", busy, 0);
        chk("R7 internal hidden flag", chg_flag, 0);

        // R7: external path latency three clocks
        usr_pad_in = 1;
        tick(); tick();
        chk("R7 external not yet visible", busy, 0);
        tick();
        chk("R7 external busy after three", busy, 1);
        chk("R8 external change", chg_flag, 1);
        clear_flags();
        usr_pad_in = 0;
        tick(); tick(); tick();
        chk("R9 external fall flag", clr_flag, 1);
        chk("R7 external busy cleared", busy, 0);
        chk("R6 usr pad input while external", usr_pad_oe, 0);

        // R12: switch back to internal (busy=1) without events
        clear_flags();
        sel = 0;
        tick();
        chk("R12 back to internal level", busy, 1);
        chk("R12 no flag on switch back", {chg_flag, clr_flag}, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule